// File: doc/BRIEF.md
# Interrupt and Trap Entry Unit

This unit sits beside the issue stage of a 64-bit in-order core and handles the entry side of exceptions. Each cycle it looks at the current machine state word, the sign bit of the decrementer and an external interrupt line. When external interrupts are enabled and a source is pending, it picks one source by fixed priority and records it. It then raises an injection request to the decoder. The decoder answers by issuing an interrupt pseudo-operation in place of the next fetched instruction.

When that pseudo-operation, or a synchronous trap operation, is executed by the unit, the unit makes the entry in one step. It saves the address of the instruction that would have run next into the first save/restore register (`srr0`). It saves the machine state word from before entry into the second (`srr1`). It produces a new machine state word with the interrupt-enable bit cleared. It drives a redirect address with a one-cycle strobe. Decrementer interrupts go to 0x900, external interrupts to 0x500 and traps to 0x700.

Top module: `irq_trap_entry`

## Requirements
- R1: During and after synchronous reset, `msr_out`, `srr0`, `srr1`, `redirect_nia`, `redirect_valid` and `inject_req` are all zero.
- R2: While bit `EE_BIT` (default 15) of `msr_in` is 0, no pending source raises `inject_req`.
- R3: With the enable bit at 1 and decrementer bit 63 at 1, `inject_req` rises one cycle later, and the resulting entry redirects to 0x900.
- R4: With the enable bit at 1, `ext_irq` high and decrementer bit 63 at 0, the resulting entry redirects to 0x500.
- R5: When both sources are pending in the same cycle, the decrementer source is the one taken (vector 0x900).
- R6: Once raised, `inject_req` stays high until a cycle in which `inject_ack` is high. It is low from the next cycle on, and it does not rise again before the pseudo-operation has executed.
- R7: The source is fixed when the request is raised. Later changes to `dec_in`, `ext_irq` or the enable bit do not change the vector used.
- R8: When `exec_irq_op` is high while an injected operation is outstanding, the unit updates its outputs on the next cycle: `srr0` = `exec_nia`, `srr1` = `msr_in`, `msr_out` = `msr_in` with bit `EE_BIT` cleared, `redirect_nia` = the vector, and `redirect_valid` high for that single cycle.
- R9: `exec_trap` makes the same state update as R8 with vector 0x700, whatever the value of the enable bit.
- R10: `exec_irq_op` has no effect when no injected operation is outstanding. No redirect follows, and `srr0`, `srr1`, `msr_out` and `redirect_nia` keep their values.
- R11: Between entries, `msr_out`, `srr0`, `srr1` and `redirect_nia` hold their last values, and `redirect_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msr_in | input | 64 | Current machine state word |
| dec_in | input | 64 | Decrementer value; bit 63 marks a pending interrupt |
| ext_irq | input | 1 | External interrupt line, level sensitive |
| inject_ack | input | 1 | Decoder has issued the interrupt pseudo-operation |
| exec_irq_op | input | 1 | The interrupt pseudo-operation is executing now |
| exec_trap | input | 1 | A trap operation is executing now |
| exec_nia | input | 64 | Address of the instruction that would execute next |
| inject_req | output | 1 | Request to the decoder to issue the pseudo-operation |
| msr_out | output | 64 | New machine state word after entry |
| srr0 | output | 64 | Saved return address |
| srr1 | output | 64 | Saved machine state word |
| redirect_nia | output | 64 | Redirect target address |
| redirect_valid | output | 1 | One-cycle redirect strobe |

## Verification
Several rules are checked on every cycle: the enable bit is cleared in `msr_out` whenever the strobe fires, `srr1` equals the state word seen one cycle earlier, the redirect target is always one of the three vectors, a request without an acknowledge persists, and no request rises while interrupts are disabled. Other behaviour depends on the sequence of stimulus, so only the bench's scenarios can show it. This covers which source wins when both are pending, that the source chosen at request time survives later changes to the inputs, that a stray pseudo-operation leaves every saved value alone, and that a trap enters with interrupts disabled.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DEC  = 2'd1,
        SRC_EXT  = 2'd2
    } irq_src_e;

    typedef enum logic [1:0] {
        INJ_IDLE = 2'd0,
        INJ_REQ  = 2'd1,
        INJ_WAIT = 2'd2
    } inj_state_e;

    localparam logic [11:0] VEC_EXT  = 12'h500;
    localparam logic [11:0] VEC_TRAP = 12'h700;
    localparam logic [11:0] VEC_DEC  = 12'h900;

    typedef struct packed {
        logic        take;
        logic [11:0] vector;
    } entry_cmd_t;

    function automatic logic [11:0] src_vector(irq_src_e s);
        case (s)
            SRC_DEC: return VEC_DEC;
            SRC_EXT: return VEC_EXT;
            default: return VEC_TRAP;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_select.sv
module irq_src_select
    import irq_entry_pkg::*;
(
    input  logic     ee,
    input  logic     dec_sign,
    input  logic     ext_line,
    output irq_src_e src
);
    always_comb begin
        src = SRC_NONE;
        if (ee) begin
            if (dec_sign)      src = SRC_DEC;
            else if (ext_line) src = SRC_EXT;
        end
    end
endmodule

// File: rtl/irq_inject_ctrl.sv
module irq_inject_ctrl
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_src_e   src,
    input  logic       ack,
    input  logic       op_exec,
    output logic       req,
    output logic       op_valid,
    output logic [11:0] vector
);
    inj_state_e state_q;
    irq_src_e   src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INJ_IDLE;
            src_q   <= SRC_NONE;
        end else begin
            case (state_q)
                INJ_IDLE: if (src != SRC_NONE) begin
                    state_q <= INJ_REQ;
                    src_q   <= src;
                end
                INJ_REQ:  if (ack) state_q <= INJ_WAIT;
                INJ_WAIT: if (op_exec) state_q <= INJ_IDLE;
                default:  state_q <= INJ_IDLE;
            endcase
        end
    end

    assign req      = (state_q == INJ_REQ);
    assign op_valid = (state_q == INJ_WAIT) && op_exec;
    assign vector   = src_vector(src_q);
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
    import irq_entry_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int EE_BIT = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  entry_cmd_t      cmd,
    input  logic [XLEN-1:0] msr_in,
    input  logic [XLEN-1:0] nia_in,
    output logic [XLEN-1:0] msr_q,
    output logic [XLEN-1:0] srr0_q,
    output logic [XLEN-1:0] srr1_q,
    output logic [XLEN-1:0] nia_q,
    output logic            strobe_q
);
    localparam logic [XLEN-1:0] EE_MASK = XLEN'(1) << EE_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q    <= '0;
            srr0_q   <= '0;
            srr1_q   <= '0;
            nia_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= cmd.take;
            if (cmd.take) begin
                msr_q  <= msr_in & ~EE_MASK;
                srr0_q <= nia_in;
                srr1_q <= msr_in;
                nia_q  <= XLEN'(cmd.vector);
            end
        end
    end
endmodule

// File: rtl/irq_trap_entry.sv
module irq_trap_entry
    import irq_entry_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int EE_BIT = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] msr_in,
    input  logic [XLEN-1:0] dec_in,
    input  logic            ext_irq,
    input  logic            inject_ack,
    input  logic            exec_irq_op,
    input  logic            exec_trap,
    input  logic [XLEN-1:0] exec_nia,
    output logic            inject_req,
    output logic [XLEN-1:0] msr_out,
    output logic [XLEN-1:0] srr0,
    output logic [XLEN-1:0] srr1,
    output logic [XLEN-1:0] redirect_nia,
    output logic            redirect_valid
);
    irq_src_e    src;
    logic        irq_take;
    logic [11:0] irq_vec;
    entry_cmd_t  cmd;

    irq_src_select u_sel (
        .ee       (msr_in[EE_BIT]),
        .dec_sign (dec_in[XLEN-1]),
        .ext_line (ext_irq),
        .src      (src)
    );

    irq_inject_ctrl u_inj (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .ack      (inject_ack),
        .op_exec  (exec_irq_op),
        .req      (inject_req),
        .op_valid (irq_take),
        .vector   (irq_vec)
    );

    always_comb begin
        cmd.take   = irq_take || exec_trap;
        cmd.vector = irq_take ? irq_vec : VEC_TRAP;
    end

    irq_entry_regs #(.XLEN(XLEN), .EE_BIT(EE_BIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .msr_in   (msr_in),
        .nia_in   (exec_nia),
        .msr_q    (msr_out),
        .srr0_q   (srr0),
        .srr1_q   (srr1),
        .nia_q    (redirect_nia),
        .strobe_q (redirect_valid)
    );
endmodule

// File: rtl/irq_trap_entry_chk.sv
module irq_trap_entry_chk #(
    parameter int XLEN   = 64,
    parameter int EE_BIT = 15
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] msr_in,
    input logic            inject_req,
    input logic            inject_ack,
    input logic            exec_irq_op,
    input logic            exec_trap,
    input logic [XLEN-1:0] msr_out,
    input logic [XLEN-1:0] srr0,
    input logic [XLEN-1:0] srr1,
    input logic [XLEN-1:0] redirect_nia,
    input logic            redirect_valid
);
    assert_no_req_when_masked_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(inject_req) |-> $past(msr_in[EE_BIT]));

    assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
        (inject_req && !inject_ack) |=> inject_req);

    assert_ee_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !msr_out[EE_BIT]);

    assert_srr1_saved_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (srr1 == $past(msr_in)));

    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> $past(exec_irq_op || exec_trap));

    assert_vector_legal_R9: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_nia == XLEN'(12'h500) || redirect_nia == XLEN'(12'h700)
                            || redirect_nia == XLEN'(12'h900)));

    assert_hold_between_R11: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid |-> ($stable(srr0) && $stable(srr1) && $stable(redirect_nia)));
endmodule

bind irq_trap_entry irq_trap_entry_chk #(.XLEN(XLEN), .EE_BIT(EE_BIT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .msr_in         (msr_in),
    .inject_req     (inject_req),
    .inject_ack     (inject_ack),
    .exec_irq_op    (exec_irq_op),
    .exec_trap      (exec_trap),
    .msr_out        (msr_out),
    .srr0           (srr0),
    .srr1           (srr1),
    .redirect_nia   (redirect_nia),
    .redirect_valid (redirect_valid)
);

// File: tb/test_irq_trap_entry.sv
module test_irq_trap_entry;
    localparam logic [63:0] EE = 64'h1 << 15;

    logic        clk = 0;
    logic        rst = 1;
    logic [63:0] msr_in = '0, dec_in = '0, exec_nia = '0;
    logic        ext_irq = 0, inject_ack = 0, exec_irq_op = 0, exec_trap = 0;
    logic        inject_req, redirect_valid;
    logic [63:0] msr_out, srr0, srr1, redirect_nia;

    int n_run = 0;
    int n_fail = 0;

    irq_trap_entry i_irq_trap_entry (
        .clk(clk), .rst(rst), .msr_in(msr_in), .dec_in(dec_in), .ext_irq(ext_irq),
        .inject_ack(inject_ack), .exec_irq_op(exec_irq_op), .exec_trap(exec_trap),
        .exec_nia(exec_nia), .inject_req(inject_req), .msr_out(msr_out), .srr0(srr0),
        .srr1(srr1), .redirect_nia(redirect_nia), .redirect_valid(redirect_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 msr_out", msr_out, 0);
        chk("R1 srr0", srr0, 0);
        chk("R1 srr1", srr1, 0);
        chk("R1 redirect_nia", redirect_nia, 0);
        chk("R1 redirect_valid", 64'(redirect_valid), 0);
        chk("R1 inject_req", 64'(inject_req), 0);
        rst = 0;
        step();
        chk("R1 inject_req after release", 64'(inject_req), 0);
    endtask

    task automatic t_masked();
        msr_in = 64'h0000_0000_0000_1002;
        dec_in = 64'h8000_0000_0000_0000;
        ext_irq = 1;
        step(3);
        chk("R2 no request while disabled", 64'(inject_req), 0);
        chk("R11 no strobe while idle", 64'(redirect_valid), 0);
        dec_in = 0;
        ext_irq = 0;
    endtask

    task automatic t_irq(string tag, logic dsign, logic ext, logic [63:0] vec,
                         logic [63:0] msr, logic [63:0] nia);
        msr_in = msr;
        dec_in = dsign ? 64'hFFFF_FFFF_FFFF_FFF0 : 64'h10;
        ext_irq = ext;
        step();
        chk({tag, " R3 request raised"}, 64'(inject_req), 1);
        dec_in = 64'h10;
        ext_irq = ~ext;
        step(2);
        chk({tag, " R6 request held"}, 64'(inject_req), 1);
        ext_irq = 0;
        inject_ack = 1;
        step();
        inject_ack = 0;
        chk({tag, " R6 request dropped"}, 64'(inject_req), 0);
        step();
        chk({tag, " R6 no re-request"}, 64'(inject_req), 0);
        exec_nia = nia;
        exec_irq_op = 1;
        step();
        exec_irq_op = 0;
        chk({tag, " R8 strobe"}, 64'(redirect_valid), 1);
        chk({tag, " R7 vector"}, redirect_nia, vec);
        chk({tag, " R8 srr0"}, srr0, nia);
        chk({tag, " R8 srr1"}, srr1, msr);
        chk({tag, " R8 msr_out"}, msr_out, msr & ~EE);
        msr_in = msr_out;
        step();
        chk({tag, " R8 strobe one cycle"}, 64'(redirect_valid), 0);
        chk({tag, " R11 vector held"}, redirect_nia, vec);
    endtask

    task automatic t_stray_op();
        logic [63:0] s0, s1, m, v;
        s0 = srr0; s1 = srr1; m = msr_out; v = redirect_nia;
        msr_in = 64'h55;
        exec_nia = 64'hDEAD_0000;
        exec_irq_op = 1;
        step();
        exec_irq_op = 0;
        chk("R10 no strobe", 64'(redirect_valid), 0);
        step();
        chk("R10 srr0 kept", srr0, s0);
        chk("R10 srr1 kept", srr1, s1);
        chk("R10 msr kept", msr_out, m);
        chk("R10 vector kept", redirect_nia, v);
    endtask

    task automatic t_trap(logic [63:0] msr, logic [63:0] nia);
        msr_in = msr;
        exec_nia = nia;
        exec_trap = 1;
        step();
        exec_trap = 0;
        chk("R9 strobe", 64'(redirect_valid), 1);
        chk("R9 vector", redirect_nia, 64'h700);
        chk("R9 srr0", srr0, nia);
        chk("R9 srr1", srr1, msr);
        chk("R9 msr_out", msr_out, msr & ~EE);
        chk("R9 no injection", 64'(inject_req), 0);
        step();
        chk("R9 strobe one cycle", 64'(redirect_valid), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_masked();
                t_irq("R3 dec", 1, 0, 64'h900, 64'h8000_0000_0000_8001, 64'h1000);
                t_irq("R4 ext", 0, 1, 64'h500, 64'h0000_0000_0000_A030, 64'h2004);
                t_irq("R5 both", 1, 1, 64'h900, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3008);
                t_stray_op();
                t_trap(64'h0000_0000_0000_0021, 64'h4000);
                t_trap(64'h0000_0000_0000_8021, 64'h4010);
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule